// File: doc/BRIEF.md
# Polyphase Column Synthesis Filter

This block performs the vertical (column) stage of a separable two-dimensional inverse wavelet transform with four-tap synthesis filters. Each valid cycle it accepts one pair of same-position subband coefficients. The pair is either the high-row pair (HL with HH) or the low-row pair (LL with LH). From that pair it produces the two upsampled output samples at rows 2p and 2p+1. Four identical multiply-add units evaluate the four polyphase equations in parallel. Units 0 and 1 finish the two current outputs by adding the pending partial sums. Units 2 and 3 form the partial sums that the next coefficient row at the same column will need.

Pending partial sums live in a register store with two parts. The first is an eight-slot intra-block area for sums used again inside the current block. The second is one inter-block row area per decomposition level, of depth N >> (D-1-level), for sums that a later block will use. An external scheduler chooses which area each access uses and supplies the level, column, path and slot. It also supplies a first-row flag that makes the pending sum read as zero at a level's top edge. Results leave through two register stages towards the row filter.

Top module: `idwt_col_synth`

## Requirements
- R1: After reset, out_vld is 0, and every stored partial sum reads as zero until it is written.
- R2: out_even = trunc(lo*h0) + trunc(hi*g0) + prior_even, where lo is in_lo and hi is in_hi.
- R3: out_odd = trunc(lo*h1) + trunc(hi*g1) + prior_odd.
- R4: On each valid cycle, trunc(lo*h2)+trunc(hi*g2) and trunc(lo*h3)+trunc(hi*g3) are stored as the new even and odd partial sums. A later access to the same entry reads them as prior_even and prior_odd.
- R5: When in_first is 1, prior_even and prior_odd are taken as zero. The write of R4 still happens.
- R6: When in_rd_intra is 1, the prior sums come from intra slot in_slot (0..7). When in_wr_intra is 1, the new sums go to that slot instead of the inter store. Intra and inter entries are independent.
- R7: Inter entries are addressed by level in_lvl (0..D-1) and index in_col*2+in_path, where in_path is 0 for the high-row pair and 1 for the low-row pair. Each level has its own entries.
- R8: trunc(a*t) is the full signed product shifted arithmetically right by FRAC and kept to its low W bits. All sums wrap modulo 2^W.
- R9: A pair presented with in_vld=1 yields out_vld=1 with its results and out_path=in_path exactly two clock edges later. Without valid input, out_vld is 0 and the result outputs hold.
- R10: An inter access with in_lvl >= D or index >= N >> (D-1-in_lvl) writes nothing and reads zero.
- R11: Cycles with in_vld=0 change no stored partial sum, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Coefficient pair valid |
| in_lo | input | W | Low-type coefficient (HL or LL), signed |
| in_hi | input | W | High-type coefficient (HH or LH), signed |
| in_path | input | 1 | 0: high-row pair, 1: low-row pair |
| in_lvl | input | LVW | Decomposition level, 0 = coarsest |
| in_col | input | COLW | Column within the level |
| in_slot | input | 3 | Intra-block slot |
| in_rd_intra | input | 1 | Read prior sums from the intra slot |
| in_wr_intra | input | 1 | Write new sums to the intra slot |
| in_first | input | 1 | First row of the level: prior sums are zero |
| out_vld | output | 1 | Output samples valid |
| out_even | output | W | Sample at row 2p, signed |
| out_odd | output | W | Sample at row 2p+1, signed |
| out_path | output | 1 | Path of the output pair |

## Verification
On every cycle the checker verifies the two-edge valid latency, the path echo and the holding of results between valid pairs. It also checks that a zero pair on a first-row access yields zero outputs. The arithmetic of both outputs, and the routing of partial sums through intra slots, per-level inter entries, out-of-range addresses and idle cycles, can only be shown by the bench. The bench does this with sequences of dependent accesses, each compared against its own model of the store.

// File: rtl/idwt_col_pkg.sv
package idwt_col_pkg;
   localparam int NUM_PHASE = 4;
   localparam int INTRA_SLOTS = 8;
   localparam int SLOT_W = 3;
   typedef enum logic {PATH_H = 1'b0, PATH_L = 1'b1} path_e;
endpackage

// File: rtl/idwt_col_mac.sv
module idwt_col_mac #(
   parameter int W      = 16,
   parameter int FRAC   = 8,
   parameter int LO_TAP = 0,
   parameter int HI_TAP = 0
) (
   input  logic signed [W-1:0] lo,
   input  logic signed [W-1:0] hi,
   output logic signed [W-1:0] term
);
   localparam logic signed [W-1:0] LT = W'(LO_TAP);
   localparam logic signed [W-1:0] HT = W'(HI_TAP);

   logic signed [2*W-1:0] p_lo, p_hi, s_lo, s_hi;

   // reduced-width products: full product, scale back, keep low W bits
   assign p_lo = $signed({{W{lo[W-1]}}, lo}) * $signed({{W{LT[W-1]}}, LT});
   assign p_hi = $signed({{W{hi[W-1]}}, hi}) * $signed({{W{HT[W-1]}}, HT});
   assign s_lo = p_lo >>> FRAC;
   assign s_hi = p_hi >>> FRAC;
   assign term = s_lo[W-1:0] + s_hi[W-1:0];
endmodule

// File: rtl/idwt_col_store.sv
module idwt_col_store
   import idwt_col_pkg::*;
#(
   parameter int W = 16,
   parameter int N = 16,
   parameter int D = 3,
   localparam int LVW  = (D > 1) ? $clog2(D) : 1,
   localparam int IDXW = $clog2(N)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                intra_rd,
   input  logic                intra_wr,
   input  logic [SLOT_W-1:0]   slot,
   input  logic [LVW-1:0]      lvl,
   input  logic [IDXW-1:0]     idx,
   input  logic signed [W-1:0] new_e,
   input  logic signed [W-1:0] new_o,
   output logic signed [W-1:0] prior_e,
   output logic signed [W-1:0] prior_o
);
   logic [W-1:0] ia_e [INTRA_SLOTS];
   logic [W-1:0] ia_o [INTRA_SLOTS];
   logic [W-1:0] lv_e [D];
   logic [W-1:0] lv_o [D];
   logic [W-1:0] inter_e, inter_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < INTRA_SLOTS; s++) begin
            ia_e[s] <= '0;
            ia_o[s] <= '0;
         end
      end else if (wr_en && intra_wr) begin
         ia_e[slot] <= new_e;
         ia_o[slot] <= new_o;
      end
   end

   for (genvar l = 0; l < D; l++) begin : g_lvl
      localparam int DEP = N >> (D - 1 - l);
      localparam int AW  = (DEP > 1) ? $clog2(DEP) : 1;
      logic [W-1:0] row_e [DEP];
      logic [W-1:0] row_o [DEP];
      logic         hit;
      assign hit = (int'(lvl) == l) && (int'(idx) < DEP);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < DEP; k++) begin
               row_e[k] <= '0;
               row_o[k] <= '0;
            end
         end else if (wr_en && !intra_wr && hit) begin
            row_e[idx[AW-1:0]] <= new_e;
            row_o[idx[AW-1:0]] <= new_o;
         end
      end

      assign lv_e[l] = hit ? row_e[idx[AW-1:0]] : '0;
      assign lv_o[l] = hit ? row_o[idx[AW-1:0]] : '0;
   end

   always_comb begin
      inter_e = '0;
      inter_o = '0;
      for (int l = 0; l < D; l++) begin
         inter_e = inter_e | lv_e[l];
         inter_o = inter_o | lv_o[l];
      end
   end

   assign prior_e = intra_rd ? ia_e[slot] : inter_e;
   assign prior_o = intra_rd ? ia_o[slot] : inter_o;
endmodule

// File: rtl/idwt_col_pipe.sv
module idwt_col_pipe #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [WIDTH-1:0] in_dat,
   output logic             out_vld,
   output logic [WIDTH-1:0] out_dat
);
   logic             v [STAGES];
   logic [WIDTH-1:0] d [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic             src_v;
      logic [WIDTH-1:0] src_d;
      if (s == 0) begin : g_head
         assign src_v = in_vld;
         assign src_d = in_dat;
      end else begin : g_body
         assign src_v = v[s-1];
         assign src_d = d[s-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v[s] <= 1'b0;
            d[s] <= '0;
         end else begin
            v[s] <= src_v;
            if (src_v) d[s] <= src_d;
         end
      end
   end

   assign out_vld = v[STAGES-1];
   assign out_dat = d[STAGES-1];
endmodule

// File: rtl/idwt_col_synth.sv
module idwt_col_synth
   import idwt_col_pkg::*;
#(
   parameter int W           = 16,
   parameter int FRAC        = 8,
   parameter int N           = 16,
   parameter int D           = 3,
   parameter int TAP_LO [4]  = '{192, 256, 64, -32},
   parameter int TAP_HI [4]  = '{-96, 160, 32, 48},
   localparam int LVW  = (D > 1) ? $clog2(D) : 1,
   localparam int COLW = $clog2(N) - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic signed [W-1:0] in_lo,
   input  logic signed [W-1:0] in_hi,
   input  logic                in_path,
   input  logic [LVW-1:0]      in_lvl,
   input  logic [COLW-1:0]     in_col,
   input  logic [2:0]          in_slot,
   input  logic                in_rd_intra,
   input  logic                in_wr_intra,
   input  logic                in_first,
   output logic                out_vld,
   output logic signed [W-1:0] out_even,
   output logic signed [W-1:0] out_odd,
   output logic                out_path
);
   localparam int IDXW = COLW + 1;
   localparam int PW   = 2 * W + 1;

   if (FRAC >= W) begin : g_bad_frac
      $error("FRAC must be below W");
   end
   if (N % (1 << D) != 0 || N < 4) begin : g_bad_n
      $error("N must be a multiple of 2**D");
   end
   for (genvar t = 0; t < NUM_PHASE; t++) begin : g_tap_chk
      if (TAP_LO[t] >= (1 << (W-1)) || TAP_LO[t] < -(1 << (W-1)) ||
          TAP_HI[t] >= (1 << (W-1)) || TAP_HI[t] < -(1 << (W-1))) begin : g_bad_tap
         $error("tap does not fit W bits");
      end
   end

   logic signed [W-1:0] term [NUM_PHASE];
   logic signed [W-1:0] prior_e, prior_o, use_e, use_o, sum_e, sum_o;
   logic [PW-1:0]       pipe_out;

   // four phase units share the same coefficient pair
   for (genvar u = 0; u < NUM_PHASE; u++) begin : g_phase
      idwt_col_mac #(.W(W), .FRAC(FRAC), .LO_TAP(TAP_LO[u]), .HI_TAP(TAP_HI[u])) u_mac (
         .lo(in_lo), .hi(in_hi), .term(term[u]));
   end

   idwt_col_store #(.W(W), .N(N), .D(D)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(in_vld),
      .intra_rd(in_rd_intra), .intra_wr(in_wr_intra), .slot(in_slot),
      .lvl(in_lvl), .idx({in_col, in_path}),
      .new_e(term[2]), .new_o(term[3]),
      .prior_e(prior_e), .prior_o(prior_o));

   assign use_e = in_first ? '0 : prior_e;
   assign use_o = in_first ? '0 : prior_o;
   assign sum_e = term[0] + use_e;
   assign sum_o = term[1] + use_o;

   idwt_col_pipe #(.WIDTH(PW), .STAGES(2)) u_pipe (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .in_dat({in_path, sum_o, sum_e}),
      .out_vld(out_vld), .out_dat(pipe_out));

   assign out_path = pipe_out[PW-1];
   assign out_odd  = pipe_out[2*W-1:W];
   assign out_even = pipe_out[W-1:0];
endmodule

// File: rtl/idwt_col_synth_chk.sv
module idwt_col_synth_chk #(
   parameter int W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_vld,
   input logic                in_first,
   input logic signed [W-1:0] in_lo,
   input logic signed [W-1:0] in_hi,
   input logic                in_path,
   input logic                out_vld,
   input logic signed [W-1:0] out_even,
   input logic signed [W-1:0] out_odd,
   input logic                out_path
);
   a_r1_idle_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !out_vld);

   a_r9_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> ##2 out_vld);

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |-> ##2 !out_vld);

   a_r9_path_echo: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> ##2 (out_path == $past(in_path, 2)));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |-> ##2 ($stable(out_even) && $stable(out_odd)));

   a_r5_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_first && in_lo == '0 && in_hi == '0) |-> ##2 (out_even == '0 && out_odd == '0));
endmodule

bind idwt_col_synth idwt_col_synth_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_first(in_first),
   .in_lo(in_lo), .in_hi(in_hi), .in_path(in_path),
   .out_vld(out_vld), .out_even(out_even), .out_odd(out_odd), .out_path(out_path));

// File: tb/idwt_col_synth_bench.sv
module idwt_col_synth_bench;
   localparam int W = 16, FRAC = 8, N = 16, D = 3;
   localparam int LVW = 2, COLW = 3;
   localparam int B_LO [4] = '{192, 256, 64, -32};
   localparam int B_HI [4] = '{-96, 160, 32, 48};

   logic clk = 0, rst_n = 0;
   logic in_vld = 0, in_path = 0, in_rd_intra = 0, in_wr_intra = 0, in_first = 0;
   logic signed [W-1:0] in_lo = '0, in_hi = '0;
   logic [LVW-1:0] in_lvl = '0;
   logic [COLW-1:0] in_col = '0;
   logic [2:0] in_slot = '0;
   logic out_vld, out_path;
   logic signed [W-1:0] out_even, out_odd;

   always #5 clk = ~clk;

   idwt_col_synth #(.W(W), .FRAC(FRAC), .N(N), .D(D), .TAP_LO(B_LO), .TAP_HI(B_HI)) u_idwt_col_synth (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_lo(in_lo), .in_hi(in_hi),
      .in_path(in_path), .in_lvl(in_lvl), .in_col(in_col), .in_slot(in_slot),
      .in_rd_intra(in_rd_intra), .in_wr_intra(in_wr_intra), .in_first(in_first),
      .out_vld(out_vld), .out_even(out_even), .out_odd(out_odd), .out_path(out_path));

   int checks = 0, fails = 0;
   int q_e[$], q_o[$], q_p[$];
   string q_tag[$];
   int m_ia_e [8], m_ia_o [8];
   int m_ir_e [4][16], m_ir_o [4][16];

   function automatic int wrapw(longint v);
      logic signed [W-1:0] t;
      t = v[W-1:0];
      return int'(t);
   endfunction

   // R8: reduced-width product
   function automatic int mulr(int a, int b);
      longint p;
      p = longint'(a) * longint'(b);
      p = p >>> FRAC;
      return wrapw(p);
   endfunction

   function automatic int phase(int lo, int hi, int u);
      return wrapw(longint'(mulr(lo, B_LO[u])) + longint'(mulr(hi, B_HI[u])));
   endfunction

   task automatic drive(int lo, int hi, int path, int lvl, int col, int slot,
                        bit rdi, bit wri, bit first, string tag);
      int pe, po, idx;
      bit ok;
      idx = col * 2 + path;
      ok  = (lvl < D) && (idx < (N >> (D - 1 - lvl)));
      if (first) begin pe = 0; po = 0; end
      else if (rdi) begin pe = m_ia_e[slot]; po = m_ia_o[slot]; end
      else if (ok) begin pe = m_ir_e[lvl][idx]; po = m_ir_o[lvl][idx]; end
      else begin pe = 0; po = 0; end
      q_e.push_back(wrapw(longint'(phase(lo, hi, 0)) + pe));
      q_o.push_back(wrapw(longint'(phase(lo, hi, 1)) + po));
      q_p.push_back(path);
      q_tag.push_back(tag);
      if (wri) begin
         m_ia_e[slot] = phase(lo, hi, 2);
         m_ia_o[slot] = phase(lo, hi, 3);
      end else if (ok) begin
         m_ir_e[lvl][idx] = phase(lo, hi, 2);
         m_ir_o[lvl][idx] = phase(lo, hi, 3);
      end
      @(negedge clk);
      in_vld = 1; in_lo = W'(lo); in_hi = W'(hi); in_path = path[0];
      in_lvl = LVW'(lvl); in_col = COLW'(col); in_slot = 3'(slot);
      in_rd_intra = rdi; in_wr_intra = wri; in_first = first;
      @(posedge clk);
   endtask

   // R11: idle cycle with arbitrary write-looking controls
   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 0; in_lo = W'($urandom); in_hi = W'($urandom);
         in_wr_intra = $urandom; in_slot = 3'($urandom); in_lvl = '0; in_col = '0;
         in_first = 0; in_path = $urandom;
         @(posedge clk);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         checks++;
         if (q_e.size() == 0) begin
            fails++;
            $display("FAIL R9: unexpected out_vld (actual 1 expected 0)");
         end else begin
            int ee, eo, ep;
            string tg;
            ee = q_e.pop_front(); eo = q_o.pop_front(); ep = q_p.pop_front(); tg = q_tag.pop_front();
            if (int'(out_even) != ee || int'(out_odd) != eo || int'(out_path) != ep) begin
               fails++;
               $display("FAIL %s: actual even=%0d odd=%0d path=%0d expected even=%0d odd=%0d path=%0d",
                        tg, out_even, out_odd, out_path, ee, eo, ep);
            end
         end
      end
   end

   initial begin
      repeat (30000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run hung (actual running expected done)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int s = 0; s < 8; s++) begin m_ia_e[s] = 0; m_ia_o[s] = 0; end
      for (int l = 0; l < 4; l++)
         for (int k = 0; k < 16; k++) begin m_ir_e[l][k] = 0; m_ir_o[l][k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (out_vld !== 1'b0) begin
         fails++;
         $display("FAIL R1: out_vld during reset actual %0b expected 0", out_vld);
      end
      rst_n = 1;
      // R1/R2/R3: stores read zero after reset
      drive(256, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
      drive(0, 256, 1, 0, 0, 0, 0, 0, 0, "R3");
      // R4: read back partial sums at the same column and path
      drive(-512, 300, 0, 0, 0, 0, 0, 0, 0, "R4");
      drive(77, -40, 1, 0, 0, 0, 0, 0, 0, "R4");
      // R6: intra slots independent of inter entries
      drive(400, 100, 0, 1, 1, 3, 0, 1, 0, "R6");
      drive(50, 60, 0, 1, 1, 5, 1, 1, 0, "R6");
      drive(-70, 33, 0, 1, 1, 3, 1, 0, 0, "R6");
      drive(10, 20, 1, 0, 0, 3, 1, 1, 0, "R6");
      // R5: first-row access ignores stored sums but still writes
      drive(123, 456, 0, 0, 0, 0, 0, 0, 1, "R5");
      drive(5, 6, 0, 0, 0, 0, 0, 0, 0, "R5");
      // R7: levels and paths keep separate entries
      drive(1000, -900, 0, 2, 7, 0, 0, 0, 0, "R7");
      drive(1, 1, 0, 1, 0, 0, 0, 0, 0, "R7");
      drive(2, 3, 0, 2, 7, 0, 0, 0, 0, "R7");
      // R10: out-of-range index and level
      drive(3000, 2000, 1, 0, 3, 0, 0, 0, 0, "R10");
      drive(11, 12, 1, 0, 3, 0, 0, 0, 0, "R10");
      drive(3000, 2000, 0, 3, 0, 0, 0, 0, 0, "R10");
      drive(11, 12, 0, 3, 0, 0, 0, 0, 0, "R10");
      // R8: wrap of products and sums
      drive(32767, 32767, 0, 1, 2, 0, 0, 0, 0, "R8");
      drive(-32768, 32767, 0, 1, 2, 0, 0, 0, 0, "R8");
      // R11: idle cycles leave the store untouched
      drive(900, -800, 1, 2, 4, 6, 0, 1, 0, "R11");
      idle(5);
      drive(0, 0, 1, 2, 4, 6, 1, 0, 0, "R11");
      drive(0, 0, 1, 2, 4, 6, 0, 0, 0, "R11");
      // R2: mixed traffic with gaps
      for (int i = 0; i < 400; i++) begin
         drive(int'($signed(16'($urandom))), int'($signed(16'($urandom))), $urandom % 2,
               $urandom % 4, $urandom % 8, $urandom % 8, $urandom % 2, $urandom % 2,
               ($urandom % 8) == 0, "R2");
         if ($urandom % 5 == 0) idle(1 + $urandom % 3);
      end
      idle(4);
      checks++;
      if (q_e.size() != 0) begin
         fails++;
         $display("FAIL R9: pending results actual %0d expected 0", q_e.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule